// File: doc/BRIEF.md
# Two-Bank Multiplexed-Address DRAM Controller with Refresh

This block sits between a 16-bit processor bus and two banks of asynchronous DRAM whose address pins carry the row and the column one after the other. When the upper address decoder enables it and the processor raises a request, the controller captures the word address, the direction and the byte enables. It puts the row on the shared pins and strobes the row strobe of the bank that the top address bit selects. It then puts the column on the same pins and strobes that bank's column strobe. For a write it drives a write enable and one active-low write strobe per byte lane. It pulses an acknowledge once, at the end of the column phase, and then holds every row strobe high for the precharge time. The data bus runs directly between the processor and the memory and does not pass through this block.

A free-running interval timer marks a refresh as due. The refresh runs between processor cycles and never interrupts an access. A refresh strobes the row strobe of both banks together and leaves the column strobes inactive. The row on the pins comes from an internal refresh counter, which advances after every refresh and wraps after the last row. A pending refresh wins over a waiting processor request. Strobe lengths, precharge time and refresh interval are parameters counted in clock cycles.

Top module: `dram_mux_ctrl`

## Requirements
- R1: While reset is applied, every RAS, CAS, write enable and lane strobe output is high, ack is low and the address pins read 0.
- R2: An access drops the RAS of exactly one bank, with the row field addr[COL_W +: ROW_W] on the pins. CAS follows exactly T_RCD cycles after RAS falls.
- R3: The bank is addr[AW-1]. During the column phase the column field addr[COL_W-1:0] is on the pins. The selected bank's CAS is low for exactly T_CAS cycles while its RAS stays low. The other bank's strobes stay high, and data lands at and returns from the addressed word.
- R4: ack is high for exactly one cycle per access, the last CAS cycle. That is T_RCD+T_CAS-1 cycles after RAS falls.
- R5: In the column phase of a write, we_n is low and lane strobe wlane_n[i] is low exactly when be[i] is 1 (bit 0 is the low byte, bit 1 the high byte). A read keeps we_n and both lane strobes high.
- R6: After any RAS-low period, all RAS outputs stay high for at least T_RP+1 cycles: T_RP precharge cycles plus one decision cycle.
- R7: While port_en is low, requests are ignored: no single-bank RAS falls, no ack is given and memory contents are unchanged.
- R8: A refresh drops both RAS outputs together for exactly T_RCD+T_CAS cycles. Both CAS outputs and we_n stay high throughout.
- R9: The refresh row on the pins starts at 0 after reset, increases by one with each refresh and wraps from 2**ROW_W-1 to 0.
- R10: With no traffic, refreshes start exactly REF_INTERVAL cycles apart.
- R11: A refresh that falls due during an access starts right after that access's precharge and idle cycle, ahead of a request already waiting. The waiting access begins T_RCD+T_CAS+T_RP+1 cycles after the refresh begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_en | input | 1 | Enable from upper address decode; gates all processor cycles |
| req | input | 1 | Processor access request, held until ack |
| wr | input | 1 | 1 = write, 0 = read |
| be | input | LANES | Byte enables, bit 0 low byte |
| addr | input | AW | Word address {bank, row, column} |
| dram_a | output | PIN_W | Multiplexed row/column address pins |
| ras_n | output | NBANK | Per-bank row strobe, active low |
| cas_n | output | NBANK | Per-bank column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| wlane_n | output | LANES | Per-byte write strobes, active low |
| ack | output | 1 | One-cycle access acknowledge |

## Verification
Every result is timed from the strobe edge that starts it. The column address and CAS are due T_RCD cycles after the bank's RAS falls, and ack is due T_RCD+T_CAS-1 cycles after that fall. A refresh's RAS-low period lasts exactly T_RCD+T_CAS cycles, successive idle refreshes are REF_INTERVAL cycles apart, and an access delayed by a refresh falls T_RCD+T_CAS+2*T_RP+3 cycles after the previous ack. The bench counts cycles with its own counter and samples all outputs at the falling clock edge. Each interval is therefore an exact difference of cycle stamps taken from the pins. The bench sweeps every address of a 3-bit row, 3-bit column, two-bank configuration with all byte-enable patterns, and checks each write lane through a behavioural memory.

// File: rtl/dramc_pkg.sv
package dramc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ROW  = 3'd1,
    ST_COL  = 3'd2,
    ST_PRE  = 3'd3,
    ST_RFSH = 3'd4
  } dram_phase_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dramc_refresh.sv
module dramc_refresh #(
  parameter int ROW_W        = 9,
  parameter int REF_INTERVAL = 1950
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_grant,
  input  logic             ref_done,
  output logic             ref_pending,
  output logic [ROW_W-1:0] ref_row
);

  localparam int TW = $clog2(REF_INTERVAL + 1);
  localparam logic [TW-1:0] RELOAD = TW'(REF_INTERVAL - 1);

  logic [TW-1:0]    tmr_q, tmr_d;
  logic             tick;
  logic             pend_d;
  logic [ROW_W-1:0] row_d;

  always_comb begin
    tick   = (tmr_q == '0);
    tmr_d  = tick ? RELOAD : tmr_q - 1'b1;
    pend_d = ref_pending;
    if (ref_grant) pend_d = 1'b0;
    if (tick)      pend_d = 1'b1;
    row_d  = ref_done ? ref_row + 1'b1 : ref_row;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q       <= RELOAD;
      ref_pending <= 1'b0;
      ref_row     <= '0;
    end else begin
      tmr_q       <= tmr_d;
      ref_pending <= pend_d;
      ref_row     <= row_d;
    end
  end

  // R9: refresh row steps by one (wrapping) after each refresh
  assert_row_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ref_done |=> (ref_row == $past(ref_row) + 1'b1));

  // R10: a due refresh is not dropped until it is granted
  assert_pending_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_pending && !ref_grant) |=> ref_pending);

endmodule

// File: rtl/dramc_seq.sv
module dramc_seq import dramc_pkg::*; #(
  parameter int T_RCD = 2,
  parameter int T_CAS = 2,
  parameter int T_RP  = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc_go,
  input  logic        ref_pending,
  output dram_phase_e phase,
  output logic        acc_grant,
  output logic        ref_grant,
  output logic        ref_done,
  output logic        ack
);

  localparam int MAXD = max2(T_RCD + T_CAS, T_RP);
  localparam int CW   = $clog2(MAXD + 1);

  dram_phase_e   ph_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          last;

  always_comb begin
    last      = (cnt_q == '0);
    ph_d      = phase;
    cnt_d     = last ? '0 : cnt_q - 1'b1;
    acc_grant = 1'b0;
    ref_grant = 1'b0;
    unique case (phase)
      ST_IDLE: begin
        if (ref_pending) begin
          ph_d      = ST_RFSH;
          cnt_d     = CW'(T_RCD + T_CAS - 1);
          ref_grant = 1'b1;
        end else if (acc_go) begin
          ph_d      = ST_ROW;
          cnt_d     = CW'(T_RCD - 1);
          acc_grant = 1'b1;
        end
      end
      ST_ROW: if (last) begin
        ph_d  = ST_COL;
        cnt_d = CW'(T_CAS - 1);
      end
      ST_COL: if (last) begin
        ph_d  = ST_PRE;
        cnt_d = CW'(T_RP - 1);
      end
      ST_PRE: if (last) ph_d = ST_IDLE;
      ST_RFSH: if (last) begin
        ph_d  = ST_PRE;
        cnt_d = CW'(T_RP - 1);
      end
      default: ph_d = ST_IDLE;
    endcase
    ack      = (phase == ST_COL)  && last;
    ref_done = (phase == ST_RFSH) && last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      phase <= ph_d;
      cnt_q <= cnt_d;
    end
  end

  // R4: acknowledge never lasts two cycles
  assert_ack_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  // R11: an idle controller with a due refresh always starts the refresh
  assert_rfsh_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == ST_IDLE && ref_pending) |=> (phase == ST_RFSH));

endmodule

// File: rtl/dramc_pinmux.sv
module dramc_pinmux import dramc_pkg::*; #(
  parameter int ROW_W  = 9,
  parameter int COL_W  = 9,
  parameter int BANK_W = 1,
  parameter int LANES  = 2,
  parameter int PIN_W  = 9,
  localparam int NBANK = 1 << BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dram_phase_e       phase,
  input  logic [BANK_W-1:0] bank,
  input  logic [ROW_W-1:0]  row,
  input  logic [COL_W-1:0]  col,
  input  logic [ROW_W-1:0]  ref_row,
  input  logic              wr,
  input  logic [LANES-1:0]  be,
  output logic [PIN_W-1:0]  dram_a,
  output logic [NBANK-1:0]  ras_n,
  output logic [NBANK-1:0]  cas_n,
  output logic              we_n,
  output logic [LANES-1:0]  wlane_n
);

  logic row_open, col_phase, rfsh_phase;

  always_comb begin
    row_open   = (phase == ST_ROW) || (phase == ST_COL);
    col_phase  = (phase == ST_COL);
    rfsh_phase = (phase == ST_RFSH);
    unique case (phase)
      ST_ROW:  dram_a = PIN_W'(row);
      ST_COL:  dram_a = PIN_W'(col);
      ST_RFSH: dram_a = PIN_W'(ref_row);
      default: dram_a = '0;
    endcase
    we_n = !(col_phase && wr);
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    assign ras_n[b] = !((row_open && (bank == BANK_W'(b))) || rfsh_phase);
    assign cas_n[b] = !(col_phase && (bank == BANK_W'(b)));

    // R3: a column strobe only ever falls inside its own row strobe
    assert_cas_under_ras_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !cas_n[b] |-> !ras_n[b]);
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign wlane_n[l] = !(col_phase && wr && be[l]);

    // R5: a lane strobe never appears outside a write
    assert_lane_in_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !wlane_n[l] |-> !we_n);
  end

  // R3: at most one bank sees a column strobe
  assert_cas_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cas_n));

  // R8: all row strobes low means a RAS-only cycle
  assert_rfsh_ras_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_n == '0) |-> (cas_n == '1 && we_n));

endmodule

// File: rtl/dram_mux_ctrl.sv
module dram_mux_ctrl import dramc_pkg::*; #(
  parameter int ROW_W        = 9,
  parameter int COL_W        = 9,
  parameter int BANK_W       = 1,
  parameter int LANES        = 2,
  parameter int T_RCD        = 2,
  parameter int T_CAS        = 2,
  parameter int T_RP         = 2,
  parameter int REF_INTERVAL = 1950,
  localparam int AW    = BANK_W + ROW_W + COL_W,
  localparam int PIN_W = (ROW_W > COL_W) ? ROW_W : COL_W,
  localparam int NBANK = 1 << BANK_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             port_en,
  input  logic             req,
  input  logic             wr,
  input  logic [LANES-1:0] be,
  input  logic [AW-1:0]    addr,
  output logic [PIN_W-1:0] dram_a,
  output logic [NBANK-1:0] ras_n,
  output logic [NBANK-1:0] cas_n,
  output logic             we_n,
  output logic [LANES-1:0] wlane_n,
  output logic             ack
);

  logic             rst_meta, rst_int_n;
  logic             acc_go, acc_grant, ref_grant, ref_done, ref_pending;
  logic [ROW_W-1:0] ref_row;
  dram_phase_e      phase;
  logic [AW-1:0]    addr_q;
  logic             wr_q;
  logic [LANES-1:0] be_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta  <= 1'b0;
      rst_int_n <= 1'b0;
    end else begin
      rst_meta  <= 1'b1;
      rst_int_n <= rst_meta;
    end
  end

  assign acc_go = req & port_en;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      addr_q <= '0;
      wr_q   <= 1'b0;
      be_q   <= '0;
    end else if (acc_grant) begin
      addr_q <= addr;
      wr_q   <= wr;
      be_q   <= be;
    end
  end

  dramc_refresh #(
    .ROW_W        (ROW_W),
    .REF_INTERVAL (REF_INTERVAL)
  ) u_refresh (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .ref_grant   (ref_grant),
    .ref_done    (ref_done),
    .ref_pending (ref_pending),
    .ref_row     (ref_row)
  );

  dramc_seq #(
    .T_RCD (T_RCD),
    .T_CAS (T_CAS),
    .T_RP  (T_RP)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .acc_go      (acc_go),
    .ref_pending (ref_pending),
    .phase       (phase),
    .acc_grant   (acc_grant),
    .ref_grant   (ref_grant),
    .ref_done    (ref_done),
    .ack         (ack)
  );

  dramc_pinmux #(
    .ROW_W  (ROW_W),
    .COL_W  (COL_W),
    .BANK_W (BANK_W),
    .LANES  (LANES),
    .PIN_W  (PIN_W)
  ) u_pinmux (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .phase   (phase),
    .bank    (addr_q[AW-1 -: BANK_W]),
    .row     (addr_q[COL_W +: ROW_W]),
    .col     (addr_q[COL_W-1:0]),
    .ref_row (ref_row),
    .wr      (wr_q),
    .be      (be_q),
    .dram_a  (dram_a),
    .ras_n   (ras_n),
    .cas_n   (cas_n),
    .we_n    (we_n),
    .wlane_n (wlane_n)
  );

  // R7: a single-bank row strobe only opens after an enabled request
  assert_port_gate_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    ($past(ras_n) == '1 && ras_n != '1 && ras_n != '0) |-> $past(port_en && req));

endmodule

// File: tb/dram_mux_ctrl_tb_top.sv
module dram_mux_ctrl_tb_top;

  localparam int ROW_W = 3, COL_W = 3, BANK_W = 1, LANES = 2;
  localparam int T_RCD = 2, T_CAS = 2, T_RP = 2, RI = 40;
  localparam int AW = BANK_W + ROW_W + COL_W;
  localparam int NW = 1 << AW;
  localparam int ROWS = 1 << ROW_W;
  localparam int RAS_LEN = T_RCD + T_CAS;

  logic clk, rst_n, port_en, req, wr;
  logic [1:0]  be;
  logic [AW-1:0] addr;
  logic [2:0]  dram_a;
  logic [1:0]  ras_n, cas_n, wlane_n;
  logic        we_n, ack;
  logic [15:0] wdata;

  logic [15:0] mem     [NW];
  logic [15:0] exp_mem [NW];

  int n_cmp, n_bad, cyc;
  bit done, mon_en;
  int exp_bank, exp_row, exp_col, exp_wr;
  logic [1:0] exp_be;
  int m_bank, ref_cnt, last_ref_cyc, ref_start, last_rise, ras_fall_cyc, cas_start;
  int acc_falls, ack_cnt;
  logic [2:0] m_row, m_col;
  logic [1:0] prev_ras, prev_cas;
  bit prev_ack, in_ref, seen_rise;

  dram_mux_ctrl #(
    .ROW_W(ROW_W), .COL_W(COL_W), .BANK_W(BANK_W), .LANES(LANES),
    .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RP(T_RP), .REF_INTERVAL(RI)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .req(req), .wr(wr), .be(be),
    .addr(addr), .dram_a(dram_a), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .wlane_n(wlane_n), .ack(ack)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, expv, cyc);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000 && !done) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
      finish_run();
    end
  end

  // pin monitor and behavioural DRAM
  always @(negedge clk) begin
    if (mon_en) begin
      if (prev_ras == 2'b11 && ras_n == 2'b00) begin
        chk(dram_a == 3'(ref_cnt % ROWS), "R9 refresh row", int'(dram_a), ref_cnt % ROWS);
        chk(cas_n == 2'b11 && we_n, "R8 cas/we idle in refresh", int'({cas_n, we_n}), 7);
        if (seen_rise) chk(cyc - last_rise >= T_RP + 1, "R6 precharge", cyc - last_rise, T_RP + 1);
        ref_cnt++;
        last_ref_cyc = cyc;
        ref_start    = cyc;
        in_ref       = 1'b1;
      end else if (prev_ras == 2'b11 && ras_n != 2'b11) begin
        m_bank = (ras_n == 2'b10) ? 0 : 1;
        m_row  = dram_a;
        chk(m_bank == exp_bank, "R3 bank select", m_bank, exp_bank);
        chk(int'(dram_a) == exp_row, "R2 row on pins", int'(dram_a), exp_row);
        chk(port_en == 1'b1, "R7 strobe with port enabled", int'(port_en), 1);
        if (seen_rise) chk(cyc - last_rise >= T_RP + 1, "R6 precharge", cyc - last_rise, T_RP + 1);
        ras_fall_cyc = cyc;
        acc_falls++;
      end
      if (prev_ras != 2'b11 && ras_n == 2'b11) begin
        if (in_ref) chk(cyc - ref_start == RAS_LEN, "R8 refresh length", cyc - ref_start, RAS_LEN);
        in_ref    = 1'b0;
        last_rise = cyc;
        seen_rise = 1'b1;
      end
      if (prev_cas == 2'b11 && cas_n != 2'b11) begin
        m_col = dram_a;
        chk(int'(dram_a) == exp_col, "R3 column on pins", int'(dram_a), exp_col);
        chk(ras_n[m_bank] == 1'b0 && cas_n[1-m_bank] == 1'b1 && ras_n[1-m_bank] == 1'b1,
            "R3 strobe pairing", int'({ras_n, cas_n}), 0);
        chk(cyc - ras_fall_cyc == T_RCD, "R2 ras-to-cas", cyc - ras_fall_cyc, T_RCD);
        chk(we_n == !exp_wr[0], "R5 write enable", int'(we_n), int'(!exp_wr[0]));
        chk(wlane_n == (exp_wr[0] ? ~exp_be : 2'b11), "R5 byte lanes", int'(wlane_n),
            int'(exp_wr[0] ? ~exp_be : 2'b11));
        cas_start = cyc;
      end
      if (prev_cas != 2'b11 && cas_n == 2'b11)
        chk(cyc - cas_start == T_CAS, "R3 cas width", cyc - cas_start, T_CAS);
      if (cas_n != 2'b11 && !we_n) begin
        for (int l = 0; l < 2; l++)
          if (!wlane_n[l]) mem[{m_bank[0], m_row, m_col}][8*l +: 8] = wdata[8*l +: 8];
      end
      if (ack) begin
        chk(cyc - ras_fall_cyc == RAS_LEN - 1, "R4 ack timing", cyc - ras_fall_cyc, RAS_LEN - 1);
        chk(!prev_ack, "R4 single ack", int'(prev_ack), 0);
        ack_cnt++;
      end
    end
    prev_ras = ras_n;
    prev_cas = cas_n;
    prev_ack = ack;
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic access(input int idx, input bit w, input logic [1:0] bev, input logic [15:0] d);
    int waited;
    step();
    exp_bank = idx >> (ROW_W + COL_W);
    exp_row  = (idx >> COL_W) % ROWS;
    exp_col  = idx % (1 << COL_W);
    exp_wr   = int'(w);
    exp_be   = bev;
    addr = AW'(idx); wr = w; be = bev; wdata = d; port_en = 1'b1; req = 1'b1;
    waited = 0;
    do begin
      step();
      waited++;
    end while (!ack && waited < 200);
    chk(ack == 1'b1, "R4 ack arrives", int'(ack), 1);
    req = 1'b0;
    if (w) begin
      for (int l = 0; l < 2; l++)
        if (bev[l]) exp_mem[idx][8*l +: 8] = d[8*l +: 8];
    end else begin
      chk(int'({m_bank[0], m_row, m_col}) == idx, "R3 decoded word", int'({m_bank[0], m_row, m_col}), idx);
      chk(mem[idx] == exp_mem[idx], "R3 read data", int'(mem[idx]), int'(exp_mem[idx]));
    end
  endtask

  initial begin
    int r0, a0, k0, ack_a, ref_a;
    for (int i = 0; i < NW; i++) begin
      mem[i] = '0;
      exp_mem[i] = '0;
    end
    rst_n = 1'b0; port_en = 1'b0; req = 1'b0; wr = 1'b0; be = '0; addr = '0; wdata = '0;
    repeat (5) step();
    chk(ras_n == 2'b11 && cas_n == 2'b11 && we_n && wlane_n == 2'b11 && !ack && dram_a == '0,
        "R1 reset outputs", int'({ras_n, cas_n, we_n, wlane_n, ack}), 'b1111_1110);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) step();
    chk(!ack && ras_n == 2'b11, "R1 quiet after reset", int'({ras_n, ack}), 6);
    prev_ras = ras_n; prev_cas = cas_n;
    mon_en = 1'b1;

    // R2 R3 R5: write every word with a rotating byte-enable pattern
    for (int i = 0; i < NW; i++)
      access(i, 1'b1, 2'(i % 4), 16'((i * 16'h0151) ^ 16'hA5C3));
    // R2 R3: read every word back
    for (int i = 0; i < NW; i++)
      access(i, 1'b0, 2'b11, 16'h0);
    // full-word overwrite and readback on a second pattern
    for (int i = 0; i < NW; i += 5) access(i, 1'b1, 2'b11, 16'(~i * 16'h3079));
    for (int i = 0; i < NW; i += 5) access(i, 1'b0, 2'b00, 16'h0);

    // R7: disabled port ignores a write request
    a0 = acc_falls; k0 = ack_cnt;
    addr = AW'(5); wr = 1'b1; be = 2'b11; wdata = 16'hFFFF; port_en = 1'b0; req = 1'b1;
    repeat (30) step();
    req = 1'b0;
    chk(acc_falls == a0, "R7 no row strobe", acc_falls - a0, 0);
    chk(ack_cnt == k0, "R7 no ack", ack_cnt - k0, 0);
    access(5, 1'b0, 2'b11, 16'h0);

    // R10: idle refresh spacing
    repeat (2) begin
      r0 = ref_cnt;
      while (ref_cnt == r0) step();
    end
    r0 = last_ref_cyc; a0 = ref_cnt;
    while (ref_cnt == a0) step();
    chk(last_ref_cyc - r0 == RI, "R10 refresh interval", last_ref_cyc - r0, RI);
    r0 = last_ref_cyc; a0 = ref_cnt;
    while (ref_cnt == a0) step();
    chk(last_ref_cyc - r0 == RI, "R10 refresh interval", last_ref_cyc - r0, RI);

    // R11: refresh falls due during an access, a second request waits
    a0 = ref_cnt;
    while (ref_cnt == a0) step();
    while (cyc != last_ref_cyc + RI - 5) step();
    access(9, 1'b1, 2'b01, 16'h1234);
    ack_a = cyc; ref_a = ref_cnt;
    access(70, 1'b1, 2'b10, 16'hBEEF);
    chk(ref_cnt == ref_a + 1, "R11 refresh ahead of request", ref_cnt - ref_a, 1);
    chk(ras_fall_cyc - ack_a == RAS_LEN + 2 * T_RP + 3, "R11 delayed access start",
        ras_fall_cyc - ack_a, RAS_LEN + 2 * T_RP + 3);
    access(9, 1'b0, 2'b11, 16'h0);
    access(70, 1'b0, 2'b11, 16'h0);

    chk(ref_cnt > ROWS, "R9 counter wrapped", ref_cnt, ROWS + 1);
    repeat (4) step();
    finish_run();
  end

endmodule